// File: doc/BRIEF.md
# Coprocessor Handshake Sequencer

This block is the pipeline-side controller that carries one coprocessor instruction through the execute stage. It listens to an attached coprocessor over two 2-bit handshake buses. One bus answers for an instruction that is about to enter execute. The other answers for an instruction that is already in execute and needs another cycle. From each answer the controller chooses one of four outcomes: raise an undefined-instruction trap, stall in busy-wait, run an execute cycle, or run the final execute cycle.

Toward the coprocessor it drives a PASS strobe and a late-cancel strobe. PASS is high in busy-wait and execute cycles. The coprocessor may commit an instruction only in a cycle where it sees PASS high and has answered GO or LAST. An interrupt request breaks a busy-wait, drops PASS and abandons the instruction so that it can be restarted later. A cancel input reports that an earlier instruction took a data abort or hit a watchpoint. It is echoed one cycle later on the late-cancel strobe. If it arrives at the end of an instruction's first execute-stage cycle, it also kills that instruction.

Internally there are four states. IDLE means no instruction is in execute. BUSYWAIT is the stall while the coprocessor is not ready. EXEC is an execute cycle, with a flag that marks it as the final one. TRAP is a single cycle that reports an undefined instruction.

Top module: `cp_handshake_seq`

## Requirements
- R1: A synchronous active-high reset puts the controller in IDLE. In the cycle after a reset edge, `pass`, `stall`, `undef_trap`, `irq_taken` and `late_cancel` are all low.
- R2: The controller samples `hs_dec` only at an edge where `cp_enter` is high and the controller is in IDLE or in a final EXEC cycle. At such an edge `hs_exe` is ignored. In BUSYWAIT and in a non-final EXEC cycle, `cp_enter` and `hs_dec` are ignored. The handshake codes are WAIT=2'b00, GO=2'b01, ABSENT=2'b10 and LAST=2'b11.
- R3: An ABSENT code, whether sampled at entry or from `hs_exe` in BUSYWAIT or in a non-final EXEC cycle, gives exactly one following cycle with `undef_trap` high and `pass` low. The controller then returns to IDLE.
- R4: A WAIT code gives BUSYWAIT in the next cycle, with `stall` and `pass` both high. The controller stays there while `hs_exe` reads WAIT and no interrupt arrives.
- R5: A GO code gives an EXEC cycle in the next cycle, with `pass` high and `stall` low. At the end of that cycle the controller samples `hs_exe`.
- R6: A LAST code gives one final EXEC cycle with `pass` high. After it the controller is in IDLE, with `pass` low, unless a new dispatch happens at that edge.
- R7: `irq` sampled high in BUSYWAIT moves the controller to IDLE and beats any GO or LAST code on `hs_exe`. In the next cycle `pass` is low and `irq_taken` is high for exactly one cycle.
- R8: `late_cancel` equals the value `abort_cancel` had at the previous clock edge, whether or not an instruction is in flight.
- R9: If `abort_cancel` is high at the edge that closes an instruction's first execute-stage cycle (BUSYWAIT or EXEC), the instruction is killed. In the next cycle the controller is in IDLE with `pass` and `stall` low, and no dispatch happens at that edge.
- R10: `irq` outside BUSYWAIT has no effect: `irq_taken` stays low and the handshake sequence is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cp_enter | input | 1 | A coprocessor instruction enters execute in the next cycle |
| hs_dec | input | 2 | Coprocessor answer for an instruction about to enter execute |
| hs_exe | input | 2 | Coprocessor answer for the instruction now in execute |
| irq | input | 1 | Interrupt request |
| abort_cancel | input | 1 | An earlier instruction took a data abort or a watchpoint hit |
| pass | output | 1 | Instruction is live in execute (busy-wait or execute cycle) |
| stall | output | 1 | Pipeline must hold (busy-wait) |
| late_cancel | output | 1 | Cancel strobe toward the coprocessor, one cycle after `abort_cancel` |
| undef_trap | output | 1 | One-cycle undefined-instruction trap request |
| irq_taken | output | 1 | One-cycle notice that an interrupt broke a busy-wait |

## Verification
If the state register goes wrong, the ports show it in the very next cycle. A stuck BUSYWAIT keeps `stall` and `pass` high after the coprocessor has answered GO. A missed final flag leaves `pass` high one cycle longer than it should be. A dropped trap removes the single `undef_trap` pulse. A wrong first-cycle flag shows up only when `abort_cancel` lines up with an instruction's first execute-stage cycle: either `pass` stays high when the instruction should have been killed, or it drops on a later cycle where it should not. The bench keeps its own model of the sequence and compares every output on every cycle, so any such divergence is caught one cycle after the edge that caused it.

// File: rtl/cphs_pkg.sv
package cphs_pkg;

    localparam int HS_W = 2;

    typedef enum logic [HS_W-1:0] {
        HS_WAIT   = 2'b00,
        HS_GO     = 2'b01,
        HS_ABSENT = 2'b10,
        HS_LAST   = 2'b11
    } hs_code_e;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'b00,
        ST_BUSYWAIT = 2'b01,
        ST_EXEC     = 2'b10,
        ST_TRAP     = 2'b11
    } seq_state_e;

    typedef struct packed {
        logic is_absent;
        logic is_wait;
        logic is_go;
        logic is_last;
    } hs_class_t;

endpackage

// File: rtl/cphs_decode.sv
module cphs_decode
    import cphs_pkg::*;
#(
    parameter int CODE_W = HS_W
) (
    input  logic [CODE_W-1:0] code,
    output hs_class_t         cls
);
    always_comb begin
        cls = '0;
        unique case (hs_code_e'(code))
            HS_ABSENT: cls.is_absent = 1'b1;
            HS_WAIT:   cls.is_wait   = 1'b1;
            HS_GO:     cls.is_go     = 1'b1;
            HS_LAST:   cls.is_last   = 1'b1;
            default:   cls.is_absent = 1'b1;
        endcase
    end
endmodule

// File: rtl/cphs_fsm.sv
module cphs_fsm
    import cphs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cp_enter,
    input  hs_class_t  dec_cls,
    input  hs_class_t  exe_cls,
    input  logic       irq,
    input  logic       abort_cancel,
    output seq_state_e state_q,
    output logic       final_q,
    output logic       irq_q
);
    seq_state_e state_n;
    logic       final_n;
    logic       first_q;
    logic       first_n;
    logic       irq_n;
    logic       kill;

    // An instruction dies if the cancel input is high as its first execute-stage cycle closes
    assign kill = abort_cancel && first_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            final_q <= 1'b0;
            first_q <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            state_q <= state_n;
            final_q <= final_n;
            first_q <= first_n;
            irq_q   <= irq_n;
        end
    end

    always_comb begin
        state_n = state_q;
        final_n = final_q;
        first_n = 1'b0;
        irq_n   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (cp_enter) begin
                    first_n = 1'b1;
                    if (dec_cls.is_absent)      state_n = ST_TRAP;
                    else if (dec_cls.is_wait)   state_n = ST_BUSYWAIT;
                    else begin
                        state_n = ST_EXEC;
                        final_n = dec_cls.is_last;
                    end
                end
            end
            ST_TRAP: begin
                state_n = ST_IDLE;
            end
            ST_BUSYWAIT: begin
                if (irq) begin
                    state_n = ST_IDLE;
                    irq_n   = 1'b1;
                end else if (kill) begin
                    state_n = ST_IDLE;
                end else if (exe_cls.is_absent) begin
                    state_n = ST_TRAP;
                end else if (exe_cls.is_go || exe_cls.is_last) begin
                    state_n = ST_EXEC;
                    final_n = exe_cls.is_last;
                end
            end
            ST_EXEC: begin
                if (kill) begin
                    state_n = ST_IDLE;
                end else if (final_q) begin
                    state_n = ST_IDLE;
                    if (cp_enter) begin
                        first_n = 1'b1;
                        if (dec_cls.is_absent)    state_n = ST_TRAP;
                        else if (dec_cls.is_wait) state_n = ST_BUSYWAIT;
                        else begin
                            state_n = ST_EXEC;
                            final_n = dec_cls.is_last;
                        end
                    end
                end else if (exe_cls.is_absent) begin
                    state_n = ST_TRAP;
                end else if (exe_cls.is_wait) begin
                    state_n = ST_BUSYWAIT;
                end else begin
                    state_n = ST_EXEC;
                    final_n = exe_cls.is_last;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/cphs_outputs.sv
module cphs_outputs
    import cphs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  seq_state_e state_q,
    input  logic       irq_q,
    input  logic       abort_cancel,
    output logic       pass,
    output logic       stall,
    output logic       undef_trap,
    output logic       irq_taken,
    output logic       late_cancel
);
    logic lc_q;

    always_ff @(posedge clk) begin
        if (rst) lc_q <= 1'b0;
        else     lc_q <= abort_cancel;
    end

    always_comb begin
        pass       = 1'b0;
        stall      = 1'b0;
        undef_trap = 1'b0;
        unique case (state_q)
            ST_IDLE:     ;
            ST_BUSYWAIT: begin
                pass  = 1'b1;
                stall = 1'b1;
            end
            ST_EXEC:     pass = 1'b1;
            ST_TRAP:     undef_trap = 1'b1;
            default:     ;
        endcase
        irq_taken   = irq_q;
        late_cancel = lc_q;
    end
endmodule

// File: rtl/cp_handshake_seq.sv
module cp_handshake_seq
    import cphs_pkg::*;
#(
    parameter int CODE_W = HS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cp_enter,
    input  logic [CODE_W-1:0] hs_dec,
    input  logic [CODE_W-1:0] hs_exe,
    input  logic              irq,
    input  logic              abort_cancel,
    output logic              pass,
    output logic              stall,
    output logic              late_cancel,
    output logic              undef_trap,
    output logic              irq_taken
);
    localparam int N_BUS   = 2;
    localparam int BUS_DEC = 0;
    localparam int BUS_EXE = 1;

    logic [N_BUS-1:0][CODE_W-1:0] bus;
    hs_class_t                    cls [N_BUS];
    seq_state_e                   state_q;
    logic                         final_q;
    logic                         irq_q;

    assign bus[BUS_DEC] = hs_dec;
    assign bus[BUS_EXE] = hs_exe;

    for (genvar g = 0; g < N_BUS; g++) begin : g_dec
        cphs_decode #(.CODE_W(CODE_W)) u_dec (
            .code (bus[g]),
            .cls  (cls[g])
        );
    end

    cphs_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .cp_enter     (cp_enter),
        .dec_cls      (cls[BUS_DEC]),
        .exe_cls      (cls[BUS_EXE]),
        .irq          (irq),
        .abort_cancel (abort_cancel),
        .state_q      (state_q),
        .final_q      (final_q),
        .irq_q        (irq_q)
    );

    cphs_outputs u_out (
        .clk          (clk),
        .rst          (rst),
        .state_q      (state_q),
        .irq_q        (irq_q),
        .abort_cancel (abort_cancel),
        .pass         (pass),
        .stall        (stall),
        .undef_trap   (undef_trap),
        .irq_taken    (irq_taken),
        .late_cancel  (late_cancel)
    );
endmodule

// File: rtl/cphs_checker.sv
module cphs_checker
    import cphs_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       cp_enter,
    input logic [1:0] hs_dec,
    input logic       irq,
    input logic       abort_cancel,
    input logic       pass,
    input logic       stall,
    input logic       late_cancel,
    input logic       undef_trap,
    input logic       irq_taken,
    input seq_state_e state_q
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!pass && !stall && !undef_trap && !irq_taken && !late_cancel));

    assert_entry_absent_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && cp_enter && hs_dec == 2'b10) |=> (undef_trap && !pass));

    assert_trap_single_R3: assert property (@(posedge clk) disable iff (rst)
        undef_trap |=> !undef_trap);

    assert_stall_has_pass_R4: assert property (@(posedge clk) disable iff (rst)
        stall |-> pass);

    assert_irq_breaks_wait_R7: assert property (@(posedge clk) disable iff (rst)
        (stall && irq) |=> (!pass && irq_taken));

    assert_irq_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        irq_taken |=> !irq_taken);

    assert_late_cancel_echo_R8: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (late_cancel == $past(abort_cancel)));

    assert_irq_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        (!stall && irq) |=> !irq_taken);
endmodule

bind cp_handshake_seq cphs_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .cp_enter     (cp_enter),
    .hs_dec       (hs_dec),
    .irq          (irq),
    .abort_cancel (abort_cancel),
    .pass         (pass),
    .stall        (stall),
    .late_cancel  (late_cancel),
    .undef_trap   (undef_trap),
    .irq_taken    (irq_taken),
    .state_q      (state_q)
);

// File: tb/sim_cp_handshake_seq.sv
module sim_cp_handshake_seq;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cp_enter = 1'b0;
    logic [1:0] hs_dec = 2'b00;
    logic [1:0] hs_exe = 2'b00;
    logic       irq = 1'b0;
    logic       abort_cancel = 1'b0;
    logic       pass, stall, late_cancel, undef_trap, irq_taken;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit started = 1'b0;

    // Model state: 0 idle, 1 busy-wait, 2 execute, 3 trap
    int m_st = 0;
    bit m_fin = 0, m_first = 0, m_irq = 0, m_lc = 0;

    localparam logic [1:0] C_WAIT = 2'b00, C_GO = 2'b01, C_ABS = 2'b10, C_LAST = 2'b11;

    always #10 clk = ~clk;

    cp_handshake_seq u0 (
        .clk(clk), .rst(rst), .cp_enter(cp_enter), .hs_dec(hs_dec), .hs_exe(hs_exe),
        .irq(irq), .abort_cancel(abort_cancel), .pass(pass), .stall(stall),
        .late_cancel(late_cancel), .undef_trap(undef_trap), .irq_taken(irq_taken)
    );

    task automatic chk(input bit got, input bit exp, input string tag);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s at cycle %0d: got %0b expected %0b", tag, cyc, got, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    // Reference model, advanced on every rising edge
    always @(posedge clk) begin
        int nst;
        bit nfin, nfirst, nirq, enter_ok;
        cyc++;
        started = 1'b1;
        if (rst) begin
            m_st = 0; m_fin = 0; m_first = 0; m_irq = 0; m_lc = 0;
        end else begin
            nst = m_st; nfin = m_fin; nfirst = 0; nirq = 0; enter_ok = 0;
            if (m_st == 0) enter_ok = 1;
            else if (m_st == 3) nst = 0;
            else if (m_st == 1) begin
                if (irq) begin nst = 0; nirq = 1; end
                else if (abort_cancel && m_first) nst = 0;
                else if (hs_exe == C_ABS) nst = 3;
                else if (hs_exe == C_GO) begin nst = 2; nfin = 0; end
                else if (hs_exe == C_LAST) begin nst = 2; nfin = 1; end
            end else begin
                if (abort_cancel && m_first) nst = 0;
                else if (m_fin) begin nst = 0; enter_ok = 1; end
                else if (hs_exe == C_ABS) nst = 3;
                else if (hs_exe == C_WAIT) nst = 1;
                else begin nst = 2; nfin = (hs_exe == C_LAST); end
            end
            if (enter_ok && cp_enter) begin
                nfirst = 1;
                case (hs_dec)
                    C_ABS:  nst = 3;
                    C_WAIT: nst = 1;
                    C_GO:   begin nst = 2; nfin = 0; end
                    default: begin nst = 2; nfin = 1; end
                endcase
            end
            m_lc = abort_cancel;
            m_st = nst; m_fin = nfin; m_first = nfirst; m_irq = nirq;
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (started) begin
            chk(pass,        (m_st == 1 || m_st == 2), "R5 pass");
            chk(stall,       (m_st == 1),              "R4 stall");
            chk(undef_trap,  (m_st == 3),              "R3 undef_trap");
            chk(irq_taken,   m_irq,                    "R7 irq_taken");
            chk(late_cancel, m_lc,                     "R8 late_cancel");
        end
    end

    // Watchdog
    always @(posedge clk) begin
        if (cyc > 100000) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_in();
        cp_enter = 0; hs_dec = C_WAIT; hs_exe = C_WAIT; irq = 0; abort_cancel = 0;
    endtask

    initial begin
        idle_in();
        rst = 1;
        tick(); tick();
        // R1: quiet outputs after reset
        chk(pass | stall | undef_trap | irq_taken | late_cancel, 1'b0, "R1 reset outputs");
        rst = 0;

        // R2 / R5 / R6: GO at entry while hs_exe reads ABSENT, then LAST
        cp_enter = 1; hs_dec = C_GO; hs_exe = C_ABS;
        tick();
        chk(pass, 1'b1, "R2 entry uses hs_dec");
        chk(undef_trap, 1'b0, "R2 hs_exe ignored at entry");
        chk(stall, 1'b0, "R5 exec no stall");
        cp_enter = 0; hs_exe = C_LAST;
        tick();
        chk(pass, 1'b1, "R6 final exec cycle");
        hs_exe = C_WAIT;
        tick();
        chk(pass, 1'b0, "R6 idle after final");

        // R4 / R3: WAIT, hold, then ABSENT from busy-wait
        cp_enter = 1; hs_dec = C_WAIT;
        tick();
        cp_enter = 0; hs_exe = C_WAIT;
        chk(stall, 1'b1, "R4 busy-wait stall");
        tick(); tick();
        chk(stall & pass, 1'b1, "R4 busy-wait holds");
        // R2: a new entry during busy-wait is ignored
        cp_enter = 1; hs_dec = C_ABS;
        tick();
        chk(stall, 1'b1, "R2 entry ignored in busy-wait");
        chk(undef_trap, 1'b0, "R2 no trap from hs_dec in busy-wait");
        cp_enter = 0; hs_exe = C_ABS;
        tick();
        chk(undef_trap, 1'b1, "R3 trap from busy-wait");
        chk(pass, 1'b0, "R3 pass low in trap");
        hs_exe = C_WAIT;
        tick();
        chk(undef_trap, 1'b0, "R3 trap single cycle");

        // R7: interrupt beats GO in busy-wait
        cp_enter = 1; hs_dec = C_WAIT;
        tick();
        cp_enter = 0;
        tick();
        irq = 1; hs_exe = C_GO;
        tick();
        chk(pass, 1'b0, "R7 pass dropped");
        chk(irq_taken, 1'b1, "R7 irq_taken");
        tick();
        chk(irq_taken, 1'b0, "R7 irq_taken one cycle");

        // R10: interrupt in idle ignored
        irq = 1;
        tick();
        chk(irq_taken, 1'b0, "R10 irq in idle");
        irq = 0;

        // R8: cancel echo with no instruction in flight
        abort_cancel = 1;
        tick();
        chk(late_cancel, 1'b1, "R8 echo without instruction");
        abort_cancel = 0;
        tick();
        chk(late_cancel, 1'b0, "R8 echo clears");

        // R9: cancel at end of first execute cycle kills the instruction
        cp_enter = 1; hs_dec = C_GO;
        tick();
        cp_enter = 0; hs_exe = C_GO; abort_cancel = 1;
        tick();
        chk(pass, 1'b0, "R9 killed after first cycle");
        chk(late_cancel, 1'b1, "R9 late_cancel with kill");
        // R9: cancel on a later cycle does not kill
        abort_cancel = 0; cp_enter = 1; hs_dec = C_GO;
        tick();
        cp_enter = 0; hs_exe = C_GO;
        tick();
        abort_cancel = 1;
        tick();
        chk(pass, 1'b1, "R9 later cancel does not kill");
        abort_cancel = 0; hs_exe = C_LAST;
        tick();
        idle_in();
        tick();

        // Mixed random traffic, compared every cycle
        for (int i = 0; i < 3000; i++) begin
            cp_enter     = ($urandom % 3) == 0;
            hs_dec       = 2'($urandom);
            hs_exe       = 2'($urandom);
            irq          = ($urandom % 8) == 0;
            abort_cancel = ($urandom % 6) == 0;
            rst          = ($urandom % 500) == 0;
            tick();
        end
        rst = 0;
        idle_in();
        tick();
        summary();
        $finish;
    end
endmodule